// File: doc/BRIEF.md
# Fixed-Format Serial Command Frame Transmitter

This block drives a single serial line, typically the input of an optical transmitter, from a master controller to one power-module controller. It repeats a short command frame on a fixed time slot, with no handshake. Each frame has a low start bit, five payload bits and a high stop bit. The payload carries two PWM-enable flags, the gate levels for the left and right bridge arms, and a software-reset request. The line stays high between frames. A receiving module locks all of its switches off whenever an enable flag arrives low. This block only guarantees that the flag reaches the line unaltered and within a bounded delay.

The slot length and the bit time are parameters counted in clocks. With a 50 MHz clock the defaults give a 400 ns bit and a 4 µs slot: 20 clocks per bit and 200 clocks per slot. A frame takes 140 clocks, and the line is idle-high for the remaining 60. The five payload inputs are captured once, on the clock that begins a frame. Input changes during a frame therefore reach the line only in the next frame.

Top module: `cmd_frame_tx`

## Requirements
- R1: While rst_ni is low the line is high. It stays high for the first SLOT_CLKS clocks after reset release, so the first frame starts at the first slot boundary.
- R2: Let k be the number of rising clock edges since reset release. A frame begins on every edge where k is a nonzero multiple of SLOT_CLKS. On that edge the line goes from high to low.
- R3: The start bit is low for exactly BIT_CLKS clocks.
- R4: After the start bit, five payload bits follow in this order: pwm_en_i[0], pwm_en_i[1], arm_pwm_i[0] (left arm), arm_pwm_i[1] (right arm), soft_rst_i. Each bit is sent at its input's level, with 1 meaning line high.
- R5: After the payload, the line is high for the stop bit and for the rest of the slot, i.e. for SLOT_CLKS - 6*BIT_CLKS clocks in total.
- R6: The payload is the value of the inputs at the frame-start edge. Input changes at any other time have no effect on the frame in progress.
- R7: Within a slot the line changes level only at a multiple of BIT_CLKS clocks from the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_en_i | input | 2 | PWM-enable flags for the module |
| arm_pwm_i | input | 2 | Gate levels: bit 0 left arm, bit 1 right arm |
| soft_rst_i | input | 1 | Software-reset request for the module |
| line_o | output | 1 | Serial line, idle high |

## Verification
The bench changes the payload inputs during frames and on the last clock before a frame start. A transmitter that read its inputs live, or captured them one clock off, would send a corrupted payload bit. The all-zero, all-one and alternating payloads expose bit order reversal and a swapped arm or enable pair. A reset applied in the middle of a frame checks that the line returns high at once and waits a full slot before the next frame. A design that started early, or stretched the start or stop bit by one clock, would fail the per-clock line comparison and the bit-boundary stability checks.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;
  localparam int unsigned PAYLOAD_W  = 5;
  localparam int unsigned FRAME_BITS = PAYLOAD_W + 2;

  // field order = wire order, LSB first
  typedef struct packed {
    logic       soft_rst;
    logic [1:0] arm;
    logic [1:0] en;
  } cmd_payload_t;
endpackage

// File: rtl/cft_slot_timer.sv
module cft_slot_timer #(
  parameter int unsigned SLOT_CLKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slot_end_o
);
  localparam int unsigned CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end_o = (cnt_q == LAST);
endmodule

// File: rtl/cft_bit_timer.sv
module cft_bit_timer #(
  parameter int unsigned BIT_CLKS   = 20,
  parameter int unsigned FRAME_BITS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic shift_o
);
  localparam int unsigned BW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] BLAST = BW'(BIT_CLKS - 1);
  localparam logic [IW-1:0] ILAST = IW'(FRAME_BITS - 1);

  logic [BW-1:0] bit_cnt_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic          tick;

  assign tick    = busy_q && (bit_cnt_q == BLAST);
  assign shift_o = tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
      busy_q    <= 1'b0;
    end else if (start_i) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
      busy_q    <= 1'b1;
    end else if (tick) begin
      bit_cnt_q <= '0;
      idx_q     <= idx_q + 1'b1;
      if (idx_q == ILAST) busy_q <= 1'b0;
    end else if (busy_q) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cft_frame_shifter.sv
module cft_frame_shifter
  import cmd_frame_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  cmd_payload_t payload_i,
  output logic         line_o
);
  logic [FRAME_BITS-1:0] sr_q;

  // ones shift in from the top, so an empty register idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '1;
    else if (load_i)   sr_q <= {1'b1, payload_i, 1'b0};
    else if (shift_i)  sr_q <= {1'b1, sr_q[FRAME_BITS-1:1]};
  end

  assign line_o = sr_q[0];
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cmd_frame_pkg::*;
#(
  parameter int unsigned BIT_CLKS  = 20,
  parameter int unsigned SLOT_CLKS = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_en_i,
  input  logic [1:0] arm_pwm_i,
  input  logic       soft_rst_i,
  output logic       line_o
);
  logic         slot_end;
  logic         shift;
  cmd_payload_t payload;

  assign payload.en       = pwm_en_i;
  assign payload.arm      = arm_pwm_i;
  assign payload.soft_rst = soft_rst_i;

  cft_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_end_o (slot_end)
  );

  cft_bit_timer #(.BIT_CLKS(BIT_CLKS), .FRAME_BITS(FRAME_BITS)) u_bit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (slot_end),
    .shift_o (shift)
  );

  cft_frame_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (slot_end),
    .shift_i   (shift),
    .payload_i (payload),
    .line_o    (line_o)
  );
endmodule

// File: rtl/cmd_frame_tx_chk.sv
module cmd_frame_tx_chk #(
  parameter int unsigned BIT_CLKS  = 20,
  parameter int unsigned SLOT_CLKS = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pwm_en_i,
  input logic [1:0] arm_pwm_i,
  input logic       soft_rst_i,
  input logic       line_o
);
  localparam int unsigned CW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [CW-1:0] c_q;
  logic          run_q;
  logic [4:0]    cap_q;
  int unsigned   pos_bit;
  logic          exp_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q   <= '0;
      run_q <= 1'b0;
      cap_q <= '0;
    end else if (c_q == CW'(SLOT_CLKS - 1)) begin
      c_q   <= '0;
      run_q <= 1'b1;
      cap_q <= {soft_rst_i, arm_pwm_i, pwm_en_i};
    end else begin
      c_q <= c_q + 1'b1;
    end
  end

  always_comb begin
    pos_bit = int'(c_q) / BIT_CLKS;
    exp_bit = 1'b1;
    for (int k = 0; k < 5; k++)
      if (pos_bit == k + 1) exp_bit = cap_q[k];
  end

  assert_idle_first_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> line_o);
  assert_frame_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && c_q == '0) |-> $fell(line_o));
  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pos_bit == 0) |-> !line_o);
  assert_payload_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pos_bit >= 1 && pos_bit <= 5) |-> line_o == exp_bit);
  assert_stop_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pos_bit >= 6) |-> line_o);
  assert_bit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(c_q) % BIT_CLKS) != 0) |-> $stable(line_o));
endmodule

bind cmd_frame_tx cmd_frame_tx_chk #(.BIT_CLKS(BIT_CLKS), .SLOT_CLKS(SLOT_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwm_en_i   (pwm_en_i),
  .arm_pwm_i  (arm_pwm_i),
  .soft_rst_i (soft_rst_i),
  .line_o     (line_o)
);

// File: tb/cmd_frame_tx_tb_top.sv
module cmd_frame_tx_tb_top;
  localparam int BIT  = 20;
  localparam int SLOT = 200;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pwm_en = '0;
  logic [1:0] arm_pwm = '0;
  logic       soft_rst = 1'b0;
  logic       line;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmd_frame_tx #(.BIT_CLKS(BIT), .SLOT_CLKS(SLOT)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pwm_en_i   (pwm_en),
    .arm_pwm_i  (arm_pwm),
    .soft_rst_i (soft_rst),
    .line_o     (line)
  );

  task automatic check(string req, logic act, logic exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s k=%0d act=%b exp=%b", req, k, act, exp);
    end
  endtask

  // k = rising edges since reset release
  function automatic logic exp_line(int k, logic [4:0] fr);
    int p;
    logic r;
    if (k < SLOT) return 1'b1;
    p = k % SLOT;
    if (p < BIT) return 1'b0;
    r = 1'b1;
    for (int b = 0; b < 5; b++)
      if (p / BIT == b + 1) r = fr[b];
    return r;
  endfunction

  function automatic logic [4:0] cur_in();
    return {soft_rst, arm_pwm, pwm_en};
  endfunction

  task automatic drive(logic [4:0] v);
    {soft_rst, arm_pwm, pwm_en} = v;
  endtask

  task automatic run_slots(int slots);
    logic [4:0] fr = '0;
    logic prev = 1'b1;
    for (int k = 0; k < slots * SLOT; k++) begin
      int p = k % SLOT;
      logic e = exp_line(k, fr);
      if (k < SLOT)             check("R1", line, e, k);
      else if (p < BIT)         check("R3", line, e, k);
      else if (p < 6 * BIT)     check((cur_in() !== fr) ? "R6" : "R4", line, e, k);
      else                      check("R5", line, e, k);
      if (k >= SLOT && p == 0)  check("R2", prev, 1'b1, k);
      if (k > 0 && (p % BIT) != 0) check("R7", line, prev, k);
      prev = line;
      // directed payloads for the first frames, random afterwards
      if (p == SLOT - 1) begin
        int f = k / SLOT;
        case (f)
          0: drive(5'b00000);
          1: drive(5'b11111);
          2: drive(5'b10101);
          3: drive(5'b01010);
          4: drive(5'b00001);
          default: drive(5'($urandom));
        endcase
        fr = cur_in();
      end else if (($urandom % 8) == 0) begin
        drive(5'($urandom));
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) begin
      @(negedge clk);
      check("R1", line, 1'b1, -1);
    end
    rst_ni = 1'b1;
    run_slots(20);
    // reset in the middle of a frame
    repeat (30) begin @(posedge clk); @(negedge clk); end
    rst_ni = 1'b0;
    drive(5'b11111);
    repeat (4) begin
      @(negedge clk);
      check("R1", line, 1'b1, -1);
    end
    rst_ni = 1'b1;
    run_slots(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule